// File: doc/BRIEF.md
# Two-bit-header block framer and serializer

This block turns one 128-bit scrambled payload and a flag that says whether the payload is data or control into a 130-bit line block. It puts a two-bit sync header in front of the payload and then sends the whole block out as a serial stream, one bit per clock. The two header bits always differ, so the serial line changes level at the start of every block. The payload bits leave the block exactly as they arrived.

An upstream stage offers payloads with a valid/ready handshake. The block takes a new payload when it is idle. It also takes one in the cycle where the last bit of the current block is on the line, so payloads that are held valid follow one another with no gap. A single-cycle start marker shows where each block begins. When no payload is waiting at a block boundary, the serial output keeps its last level and no start marker appears.

Top module: `blk130_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1, blk_start is 0 and ser_bit is 0.
- R2: Every accepted payload produces exactly 130 serial bits: 2 header bits followed by 128 payload bits. Every block that is accepted is sent.
- R3: For a data block (in_ctrl = 0), the first header bit sent is 0 and the second is 1.
- R4: For a control block (in_ctrl = 1), the first header bit sent is 1 and the second is 0.
- R5: The payload is sent unaltered in bit order in_data[0] first through in_data[127] last. Header bit k sits at stream position k and payload bit i at stream position 2+i.
- R6: blk_start is 1 for exactly the one cycle in which the first header bit is on ser_bit. That cycle is the cycle right after a handshake (in_valid and in_ready both 1 at a rising edge).
- R7: in_ready is 0 while stream positions 0 to 128 are on the line and 1 at position 129. A payload held valid is therefore accepted on the last bit, and its first header bit follows with no idle cycle.
- R8: When no payload is accepted at a block boundary, ser_bit keeps the level of the last bit sent and blk_start stays 0 until a payload is accepted.
- R9: in_data and in_ctrl have no effect on the output in any cycle where in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A payload is offered |
| in_ready | output | 1 | The block takes the offered payload at the next rising edge |
| in_data | input | 128 | Scrambled payload; bit 0 is sent first |
| in_ctrl | input | 1 | Block type: 0 means data, 1 means control |
| ser_bit | output | 1 | Serial line bit |
| blk_start | output | 1 | High while the first header bit is on ser_bit |

## Verification
Sending the final bit of one block and accepting the next payload happen in the same cycle whenever a payload is already waiting. The bench provokes this by offering every third payload back-to-back, with in_valid held from the very first bit of the block in flight. It then counts the clock cycles spent waiting until in_ready rises, and that count must be exactly 129. A deserializing monitor checks that the next block's start marker, header and payload follow right after bit 129 with no idle cycle and no lost or shifted bit. Every data and control type is swept across all-zero, all-one, alternating, walking-one and arithmetic payloads. Between blocks the bench drives junk on in_data and in_ctrl with in_valid low.

// File: rtl/blk130_pkg.sv
// Package: shared constants and helpers for the 130-bit block framer.
// Assumes the header is two bits wide and that bit 0 of any frame vector
// is the first bit placed on the serial line.
package blk130_pkg;

    localparam int unsigned SYNC_W = 2;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CTRL = 1'b1
    } blk_kind_e;

    // Header bits in send order (bit 0 first): data -> 0,1 ; control -> 1,0.
    function automatic logic [SYNC_W-1:0] sync_bits(input blk_kind_e kind);
        return (kind == KIND_CTRL) ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/blk130_frame_gen.sv
// Module: builds the full frame vector from a payload and its type flag.
// Purely combinational. Frame bit 0 is sent first: the header comes first,
// then payload bit 0 through payload bit PAYLOAD_W-1, none of them altered.
module blk130_frame_gen
    import blk130_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = 128,
    localparam int unsigned FRAME_W  = PAYLOAD_W + SYNC_W
) (
    input  logic                 kind_ctrl,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic [FRAME_W-1:0]   frame
);

    logic [SYNC_W-1:0] hdr;

    // Pick the header pattern for the block type.
    always_comb begin
        hdr = sync_bits(kind_ctrl ? KIND_CTRL : KIND_DATA);
    end

    // Place header bits in the lowest frame positions.
    for (genvar h = 0; h < SYNC_W; h++) begin : g_hdr
        assign frame[h] = hdr[h];
    end

    // Place payload bits after the header, preserving their order.
    for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_pay
        assign frame[SYNC_W + i] = payload[i];
    end

endmodule

// File: rtl/blk130_seq.sv
// Module: bit-position sequencer for the framer.
// Tracks whether a block is on the line and which bit is showing. It raises
// ready when idle or on the last bit, so the next frame loads with no gap.
// Assumes FRAME_W >= 2.
module blk130_seq #(
    parameter int unsigned FRAME_W = 130,
    localparam int unsigned IDX_W  = $clog2(FRAME_W),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic shift_en,
    output logic blk_start
);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic             start_q;
    logic             on_last;

    // Decode the last frame position and the handshake.
    always_comb begin
        on_last  = active_q && (idx_q == LAST_IDX);
        in_ready = !active_q || on_last;
        load     = in_valid && in_ready;
        shift_en = active_q && !on_last;
    end

    // Advance the bit position; start a new frame on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= load;
            if (load) begin
                active_q <= 1'b1;
                idx_q    <= '0;
            end else if (on_last) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign blk_start = start_q;

endmodule

// File: rtl/blk130_shreg.sv
// Module: output shift register.
// On load it shows frame bit 0 and keeps the rest. On each shift it shows the
// next bit. Otherwise it holds, so the line keeps its last level when idle.
module blk130_shreg #(
    parameter int unsigned FRAME_W = 130
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift_en,
    input  logic [FRAME_W-1:0] frame,
    output logic               ser_bit
);

    logic               ser_q;
    logic [FRAME_W-2:0] rest_q;

    // Load a fresh frame or step one bit toward the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q  <= 1'b0;
            rest_q <= '0;
        end else if (load) begin
            ser_q  <= frame[0];
            rest_q <= frame[FRAME_W-1:1];
        end else if (shift_en) begin
            ser_q  <= rest_q[0];
            rest_q <= {1'b0, rest_q[FRAME_W-2:1]};
        end
    end

    assign ser_bit = ser_q;

endmodule

// File: rtl/blk130_tx.sv
// Module: top of the 130-bit block framer and serializer.
// Takes a scrambled payload and a type flag through valid/ready, adds a
// two-bit header and sends one bit per clock. Assumes the upstream stage
// holds in_data/in_ctrl stable while in_valid is high and in_ready is low.
module blk130_tx
    import blk130_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = 128,
    localparam int unsigned FRAME_W  = PAYLOAD_W + SYNC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PAYLOAD_W-1:0] in_data,
    input  logic                 in_ctrl,
    output logic                 ser_bit,
    output logic                 blk_start
);

    logic [FRAME_W-1:0] frame;
    logic               load;
    logic               shift_en;

    blk130_frame_gen #(.PAYLOAD_W(PAYLOAD_W)) u_frame (
        .kind_ctrl (in_ctrl),
        .payload   (in_data),
        .frame     (frame)
    );

    blk130_seq #(.FRAME_W(FRAME_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load      (load),
        .shift_en  (shift_en),
        .blk_start (blk_start)
    );

    blk130_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .frame    (frame),
        .ser_bit  (ser_bit)
    );

endmodule

// File: rtl/blk130_tx_chk.sv
// Module: protocol checker bound to blk130_tx; it looks only at the ports.
// Assumes a synchronous active-low reset; checks start one cycle after release.
module blk130_tx_chk #(
    parameter int unsigned FRAME_W = 130,
    localparam int unsigned CW     = $clog2(FRAME_W + 1) + 1,
    localparam logic [CW-1:0] SAT  = {CW{1'b1}}
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_ctrl,
    input logic ser_bit,
    input logic blk_start
);

    logic          armed_q;
    logic          seen_q;
    logic [CW-1:0] since_q;

    // Arm the checks one cycle after reset release; measure start spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            seen_q  <= 1'b0;
            since_q <= '0;
        end else begin
            armed_q <= 1'b1;
            if (blk_start) begin
                seen_q  <= 1'b1;
                since_q <= CW'(1);
            end else if (since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        blk_start == $past(in_valid && in_ready)); // R6

    AST_DATA_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (blk_start && !$past(in_ctrl)) |-> !ser_bit); // R3

    AST_CTRL_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (blk_start && $past(in_ctrl)) |-> ser_bit); // R4

    AST_HDR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        blk_start |=> (ser_bit != $past(ser_bit))); // R3

    AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        blk_start |-> !in_ready); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(in_ready && !in_valid) |-> ($stable(ser_bit) && !blk_start)); // R8

    AST_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (blk_start && seen_q) |-> (since_q >= CW'(FRAME_W))); // R2

endmodule

bind blk130_tx blk130_tx_chk #(.FRAME_W(PAYLOAD_W + 2)) u_blk130_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_ctrl   (in_ctrl),
    .ser_bit   (ser_bit),
    .blk_start (blk_start)
);

// File: tb/tb_blk130_tx.sv
// Bench: sweeps payload patterns and both block types, deserializes the line
// and compares each block against values computed here.
module tb_blk130_tx;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 128;
    localparam int FW         = PW + 2;
    localparam int NPAT       = 12;
    localparam int WD_CYCLES  = 60000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_data = '0;
    logic          in_ctrl = 1'b0;
    logic          ser_bit;
    logic          blk_start;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    logic [PW-1:0] exp_data [0:63];
    logic          exp_ctrl [0:63];
    int            nsent = 0;
    int            nrx = 0;

    blk130_tx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_ctrl   (in_ctrl),
        .ser_bit   (ser_bit),
        .blk_start (blk_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [FW-1:0] act, input logic [FW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pattern(input int p);
        logic [PW-1:0] v;
        int pos [6] = '{0, 1, 63, 64, 126, 127};
        v = '0;
        case (p)
            0: v = '0;
            1: v = '1;
            2: v = {64{2'b10}};
            3: v = {64{2'b01}};
            4, 5, 6, 7, 8, 9: v[pos[p-4]] = 1'b1;
            default: for (int w = 0; w < 4; w++)
                v[32*w +: 32] = 32'h9E37_79B9 * (w + 1 + 7*p);
        endcase
        return v;
    endfunction

    // Offer one payload after 'pre' cycles of junk with valid low.
    task automatic send(input logic [PW-1:0] d, input logic c, input int pre,
                        input bit b2b);
        int waits = 0;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = ~d ^ {4{32'hA5A5_0000 + 32'(i)}};
            in_ctrl  = ~c;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_ctrl  = c;
        while (!in_ready) begin
            @(negedge clk);
            waits++;
        end
        exp_data[nsent] = d;
        exp_ctrl[nsent] = c;
        nsent++;
        if (b2b)  // R7: held payload accepted exactly on bit 129
            check(waits == FW - 1, "R7 back-to-back wait", FW'(waits), FW'(FW - 1));
        @(posedge clk);
    endtask

    // Monitor: deserialize at the falling edge and judge each block.
    bit            cap_on = 0;
    bit            have_last = 0;
    logic          last_bit = 1'b0;
    int            pos = 0;
    logic [FW-1:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (blk_start) begin
                // R2 R6: start only after a complete block
                if (cap_on)
                    check(1'b0, "R2 block cut short", FW'(pos), FW'(FW));
                cap_on = 1;
                pos = 0;
            end else if (!cap_on && have_last) begin
                // R8 R9: idle line holds last level
                check(ser_bit == last_bit, "R8 idle hold", FW'(ser_bit), FW'(last_bit));
            end
            if (cap_on) begin
                cap[pos] = ser_bit;
                check(in_ready == (pos == FW - 1), "R7 ready position",
                      FW'(in_ready), FW'(pos == FW - 1));
                pos++;
                if (pos == FW) begin
                    cap_on = 0;
                    have_last = 1;
                    last_bit = ser_bit;
                    if (nrx < nsent) begin
                        if (exp_ctrl[nrx])
                            check(cap[1:0] == 2'b01, "R4 control header",
                                  FW'(cap[1:0]), FW'(2'b01));
                        else
                            check(cap[1:0] == 2'b10, "R3 data header",
                                  FW'(cap[1:0]), FW'(2'b10));
                        check(cap[FW-1:2] == exp_data[nrx], "R5 R9 payload order",
                              FW'(cap[FW-1:2]), FW'(exp_data[nrx]));
                    end else begin
                        check(1'b0, "R2 unexpected block", FW'(nrx), FW'(nsent));
                    end
                    nrx++;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 ready in reset", FW'(in_ready), FW'(1));
        check(blk_start == 1'b0, "R1 start in reset", FW'(blk_start), FW'(0));
        check(ser_bit == 1'b0, "R1 line in reset", FW'(ser_bit), FW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !blk_start && !ser_bit, "R1 after release",
              FW'({in_ready, blk_start, ser_bit}), FW'(3'b100));
        for (int k = 0; k < 2; k++) begin
            for (int p = 0; p < NPAT; p++) begin
                send(pattern(p), k[0], n % 3, (n % 3 == 0) && (n != 0));
                n++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '1;
        in_ctrl  = 1'b1;
        repeat (FW + 40) @(negedge clk);
        check(nrx == nsent, "R2 blocks sent", FW'(nrx), FW'(nsent));
        check(!blk_start && in_ready, "R8 final idle",
              FW'({blk_start, in_ready}), FW'(2'b01));
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule